// File: doc/BRIEF.md
# SPI Byte-Addressed Register Slave

This block lets a host reach a small map of 16-bit registers over a four-wire serial link in clock mode 3. The serial clock idles high, the slave samples its data input on rising edges and changes its data output on falling edges. Every transfer is exactly sixteen clocks long and carries one command. The command is a write/read flag, a fixed zero bit, a six-bit byte address and an eight-bit data field. A write changes only the byte it names. A read loads the whole 16-bit word into an output holder, and the host shifts that word out during its next transfer. Back-to-back reads can therefore be pipelined in full duplex.

The serial pins are brought into the system clock domain through two-stage synchronisers, and all frame handling runs on the system clock. Example contents: two sampled data words, each with a new-data flag in bit 15, an error/alarm flag in bit 14 and a 14-bit value. There are two read/write configuration words and a status word. Bit 0 of the status word records an aborted transfer.

Word map (byte addresses, odd = bits 15:8, even = bits 7:0): X data 0x02/0x03, Y data 0x04/0x05, configuration A 0x10/0x11 (reset 0x0000), configuration B 0x12/0x13 (reset 0x0800), status 0x3C/0x3D. All other addresses read as zero.

Top module: `spi_regslave`

## Requirements
- R1: After reset, the output enable is low and the first complete transfer returns 0x0000 on the data output.
- R2: A write command (bit 15 = 1, bits 13:8 = byte address, bits 7:0 = data) to an even address changes only bits 7:0 of the selected configuration word. The same command to an odd address changes only bits 15:8.
- R3: A read command (bit 15 = 0) returns the full 16-bit word, most significant bit first, during the next transfer. Either byte address of the pair selects the same word.
- R4: In a read command the low eight input bits have no effect on any register.
- R5: The transfer that follows a write command returns 0x0000.
- R6: A sample update sets bit 15 of both data words. A read of a data word returns the flag as set and clears it, so a repeat read with no update returns bit 15 = 0.
- R7: Bit 14 of each data word holds the alarm input value captured with the latest sample update.
- R8: If chip select rises after 1 to 15 clocks, the transfer is discarded and status bit 0 is set. The next transfer returns 0x0000. A read of the status word returns the bit and clears it.
- R9: While chip select is high, the output enable stays low and clock and data-input activity has no effect.
- R10: Writes to the data words or to unmapped addresses have no effect, and unmapped addresses read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso (low = high impedance) |
| samp_valid | input | 1 | One-cycle pulse loading a new sample |
| samp_x | input | 14 | X sample value |
| samp_y | input | 14 | Y sample value |
| samp_alarm | input | 1 | Alarm state captured with the sample |

## Verification
The assertions assume that every serial clock half-period and every chip-select setup and hold interval spans several system clocks. This lets the synchronisers see each edge as its own pulse, so chip-select edges and clock edges never arrive in the same cycle. The stimulus keeps every half-period at eight system clocks and waits eight or more clocks around each chip-select edge. Sample updates are driven only while chip select is high, between transfers, so an update never coincides with a read capture.

// File: rtl/spi_regslave_pkg.sv
// Shared constants and the command layout of the serial register slave.
// Assumes a 16-bit frame: write flag, fixed zero, 6-bit address, 8-bit data.
package spi_regslave_pkg;
    localparam int FRAME_BITS  = 16;
    localparam int ADDR_BITS   = 6;
    localparam int BYTE_BITS   = 8;
    localparam int WORD_BITS   = 16;
    localparam int SAMPLE_BITS = 14;
    localparam int WIDX_BITS   = ADDR_BITS - 1;

    localparam logic [WIDX_BITS-1:0] WIDX_XDATA    = 5'd1;
    localparam logic [WIDX_BITS-1:0] WIDX_YDATA    = 5'd2;
    localparam logic [WIDX_BITS-1:0] WIDX_CFG_BASE = 5'd8;
    localparam logic [WIDX_BITS-1:0] WIDX_STATUS   = 5'd30;

    typedef struct packed {
        logic                 wr;
        logic                 fixed_zero;
        logic [ADDR_BITS-1:0] addr;
        logic [BYTE_BITS-1:0] data;
    } spi_cmd_t;
endpackage

// File: rtl/spi_edge_sync.sv
// Brings chip select, serial clock and data input into the system clock
// domain and derives one-cycle edge pulses. Assumes each serial level lasts
// longer than STAGES+1 system clocks.
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_act,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
    logic              sclk_d, cs_d;

    // Purpose: shift the raw pins through the synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '1;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b1;
            cs_d   <= 1'b1;
        end else begin
            sclk_q <= {sclk_q[STAGES-2:0], sclk_in};
            cs_q   <= {cs_q[STAGES-2:0], cs_n_in};
            mosi_q <= {mosi_q[STAGES-2:0], mosi_in};
            sclk_d <= sclk_q[TOP];
            cs_d   <= cs_q[TOP];
        end
    end

    assign sclk_rise = sclk_q[TOP] & ~sclk_d;
    assign sclk_fall = ~sclk_q[TOP] & sclk_d;
    assign cs_fall   = ~cs_q[TOP] & cs_d;
    assign cs_rise   = cs_q[TOP] & ~cs_d;
    assign cs_act    = ~cs_q[TOP];
    assign mosi_s    = mosi_q[TOP];
endmodule

// File: rtl/spi_frame_engine.sv
// Counts serial clocks within a frame, assembles the received word,
// launches the transmit word MSB first and flags complete or aborted frames.
// Assumes edge pulses from spi_edge_sync; mode 3 timing.
module spi_frame_engine #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  cs_act,
    input  logic                  mosi_s,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  tx_load,
    output logic                  frame_done,
    output logic                  frame_abort,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  miso,
    output logic                  miso_oe
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] rx_sh;
    logic [FRAME_BITS-1:0] tx_sh;
    logic                  mid_frame;

    assign mid_frame = (bit_cnt != '0) && (bit_cnt != CNT_FULL);

    // Purpose: count rising edges, shift in data, report end or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            rx_sh       <= '0;
            rx_word     <= '0;
            frame_done  <= 1'b0;
            frame_abort <= 1'b0;
        end else begin
            frame_done  <= 1'b0;
            frame_abort <= 1'b0;
            if (cs_fall) begin
                bit_cnt <= '0;
            end else if (cs_act && sclk_rise && bit_cnt != CNT_FULL) begin
                rx_sh   <= {rx_sh[FRAME_BITS-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_LAST) begin
                    frame_done <= 1'b1;
                    rx_word    <= {rx_sh[FRAME_BITS-2:0], mosi_s};
                end
            end
            if (cs_rise && mid_frame) begin
                frame_abort <= 1'b1;
            end
        end
    end

    // Purpose: load the reply at frame start and shift it on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            if (cs_fall) begin
                tx_sh   <= tx_word;
                tx_load <= 1'b1;
            end else if (cs_act && sclk_fall && mid_frame) begin
                tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    assign miso    = tx_sh[FRAME_BITS-1];
    assign miso_oe = cs_act;
endmodule

// File: rtl/spi_cmd_decode.sv
// Splits a completed frame into byte-lane write strobes, a read request,
// the word index and the write data. Purely combinational.
module spi_cmd_decode
    import spi_regslave_pkg::*;
#(
    parameter int FRAME_BITS = spi_regslave_pkg::FRAME_BITS
) (
    input  logic                  frame_done,
    input  logic [FRAME_BITS-1:0] rx_word,
    output logic                  wr_lo,
    output logic                  wr_hi,
    output logic                  rd_req,
    output logic [WIDX_BITS-1:0]  widx,
    output logic [BYTE_BITS-1:0]  wdata
);
    spi_cmd_t cmd;

    // Purpose: view the frame as a command and derive strobes.
    always_comb begin
        cmd    = spi_cmd_t'(rx_word);
        widx   = cmd.addr[ADDR_BITS-1:1];
        wdata  = cmd.data;
        wr_lo  = frame_done &  cmd.wr & ~cmd.addr[0];
        wr_hi  = frame_done &  cmd.wr &  cmd.addr[0];
        rd_req = frame_done & ~cmd.wr;
    end
endmodule

// File: rtl/spi_reg_bank.sv
// Holds the example register map, applies byte writes, captures read words
// with their side effects and keeps the reply holder for the next frame.
// Assumes sample updates are single-cycle pulses.
module spi_reg_bank
    import spi_regslave_pkg::*;
#(
    parameter int WORD_BITS   = spi_regslave_pkg::WORD_BITS,
    parameter int SAMPLE_BITS = spi_regslave_pkg::SAMPLE_BITS,
    parameter int NUM_CFG     = 2,
    parameter logic [NUM_CFG-1:0][WORD_BITS-1:0] CFG_RESET = {16'h0800, 16'h0000}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_lo,
    input  logic                   wr_hi,
    input  logic                   rd_req,
    input  logic [WIDX_BITS-1:0]   widx,
    input  logic [BYTE_BITS-1:0]   wdata,
    input  logic                   frame_abort,
    input  logic                   tx_load,
    input  logic                   samp_valid,
    input  logic [SAMPLE_BITS-1:0] samp_x,
    input  logic [SAMPLE_BITS-1:0] samp_y,
    input  logic                   samp_alarm,
    output logic [WORD_BITS-1:0]   tx_word
);
    localparam int HI_LSB = WORD_BITS - BYTE_BITS;

    logic [NUM_CFG-1:0][WORD_BITS-1:0] cfg_rd;
    logic [SAMPLE_BITS-1:0] x_q, y_q;
    logic                   nd_x, nd_y, ea_x, ea_y;
    logic                   fail_q;
    logic [WORD_BITS-1:0]   rd_word;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        logic [WORD_BITS-1:0] q;
        logic                 hit;
        assign hit = (widx == WIDX_CFG_BASE + WIDX_BITS'(g));
        // Purpose: byte-lane update of one configuration word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= CFG_RESET[g];
            end else if (hit) begin
                if (wr_lo) q[BYTE_BITS-1:0]         <= wdata;
                if (wr_hi) q[WORD_BITS-1:HI_LSB]    <= wdata;
            end
        end
        assign cfg_rd[g] = q;
    end

    // Purpose: capture samples and manage new-data flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            nd_x <= 1'b0;
            nd_y <= 1'b0;
            ea_x <= 1'b0;
            ea_y <= 1'b0;
        end else if (samp_valid) begin
            x_q  <= samp_x;
            y_q  <= samp_y;
            nd_x <= 1'b1;
            nd_y <= 1'b1;
            ea_x <= samp_alarm;
            ea_y <= samp_alarm;
        end else if (rd_req) begin
            if (widx == WIDX_XDATA) nd_x <= 1'b0;
            if (widx == WIDX_YDATA) nd_y <= 1'b0;
        end
    end

    // Purpose: record aborted frames, clear on status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (frame_abort) begin
            fail_q <= 1'b1;
        end else if (rd_req && widx == WIDX_STATUS) begin
            fail_q <= 1'b0;
        end
    end

    // Purpose: select the word named by the read command.
    always_comb begin
        rd_word = '0;
        if (widx == WIDX_XDATA) begin
            rd_word = {nd_x, ea_x, x_q};
        end else if (widx == WIDX_YDATA) begin
            rd_word = {nd_y, ea_y, y_q};
        end else if (widx == WIDX_STATUS) begin
            rd_word = {{(WORD_BITS-1){1'b0}}, fail_q};
        end
        for (int i = 0; i < NUM_CFG; i++) begin
            if (widx == WIDX_CFG_BASE + WIDX_BITS'(i)) rd_word = cfg_rd[i];
        end
    end

    // Purpose: hold the reply for the next frame; consumed at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
        end else if (rd_req) begin
            tx_word <= rd_word;
        end else if (tx_load) begin
            tx_word <= '0;
        end
    end
endmodule

// File: rtl/spi_regslave.sv
// Top of the serial register slave: synchroniser, frame engine, command
// decoder and register bank. Assumes system clock much faster than SCLK.
module spi_regslave
    import spi_regslave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_cs_n,
    input  logic                   spi_sclk,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   spi_miso_oe,
    input  logic                   samp_valid,
    input  logic [SAMPLE_BITS-1:0] samp_x,
    input  logic [SAMPLE_BITS-1:0] samp_y,
    input  logic                   samp_alarm
);
    logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_act, mosi_s;
    logic tx_load, frame_done, frame_abort;
    logic [FRAME_BITS-1:0] rx_word;
    logic [WORD_BITS-1:0]  tx_word;
    logic wr_lo, wr_hi, rd_req;
    logic [WIDX_BITS-1:0] widx;
    logic [BYTE_BITS-1:0] wdata;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    spi_frame_engine #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_act(cs_act), .mosi_s(mosi_s),
        .tx_word(tx_word), .tx_load(tx_load),
        .frame_done(frame_done), .frame_abort(frame_abort), .rx_word(rx_word),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    spi_cmd_decode #(.FRAME_BITS(FRAME_BITS)) u_dec (
        .frame_done(frame_done), .rx_word(rx_word),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_req(rd_req),
        .widx(widx), .wdata(wdata)
    );

    spi_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_req(rd_req),
        .widx(widx), .wdata(wdata),
        .frame_abort(frame_abort), .tx_load(tx_load),
        .samp_valid(samp_valid), .samp_x(samp_x), .samp_y(samp_y),
        .samp_alarm(samp_alarm),
        .tx_word(tx_word)
    );
endmodule

// File: rtl/spi_regslave_chk.sv
// Checker for spi_regslave, attached by bind. Relates chip select, the
// drive enable, the decoder strobes and the reply holder over time.
module spi_regslave_chk #(
    parameter int WORD_BITS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 spi_cs_n,
    input logic                 spi_miso_oe,
    input logic                 wr_lo,
    input logic                 wr_hi,
    input logic                 rd_req,
    input logic                 frame_done,
    input logic                 frame_abort,
    input logic                 tx_load,
    input logic [WORD_BITS-1:0] tx_word
);
    // R9
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso_oe);

    // R2
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo && wr_hi));

    // R8
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && frame_abort));

    // R5
    write_reply_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> (tx_word == '0));

    // R3
    reply_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_word) |-> ($past(rd_req) || $past(tx_load)));
endmodule

bind spi_regslave spi_regslave_chk #(.WORD_BITS(spi_regslave_pkg::WORD_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_req(rd_req),
    .frame_done(frame_done), .frame_abort(frame_abort),
    .tx_load(tx_load), .tx_word(tx_word)
);

// File: tb/spi_regslave_test.sv
// Scoreboard bench: the frame driver pushes the expected reply for each
// frame, the monitor pops received and expected words and compares them.
module spi_regslave_test;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sclk = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic samp_valid = 1'b0, samp_alarm = 1'b0;
    logic [13:0] samp_x = '0, samp_y = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic [15:0] val; string tag; } exp_t;
    exp_t        exp_q[$];
    logic [15:0] got_q[$];

    logic [15:0] exp_next = 16'h0000;
    string       exp_tag  = "R1";
    logic [15:0] m_cfga = 16'h0000, m_cfgb = 16'h0800;
    logic [13:0] m_x = '0, m_y = '0;
    logic        m_ndx = 0, m_ndy = 0, m_eax = 0, m_eay = 0, m_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_regslave uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .samp_valid(samp_valid), .samp_x(samp_x), .samp_y(samp_y),
        .samp_alarm(samp_alarm)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Monitor: compare each received reply with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0 && got_q.size() > 0) begin
                exp_t e;
                logic [15:0] g;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                check(e.tag, g, e.val);
            end
        end
    end

    task automatic spi_xfer(input logic [15:0] cmd, input int nbits, output logic [15:0] rx);
        rx = '0;
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (HALF) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            spi_sclk = 1'b0;
            spi_mosi = cmd[15-i];
            repeat (HALF) @(posedge clk);
            @(negedge clk);
            rx[15-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(posedge clk);
        end
        repeat (HALF) @(posedge clk);
        @(negedge clk) spi_cs_n = 1'b1;
        repeat (10) @(posedge clk);
    endtask

    task automatic model_read(input logic [5:0] addr, output logic [15:0] w);
        case (addr[5:1])
            5'd1:  begin w = {m_ndx, m_eax, m_x}; m_ndx = 0; end
            5'd2:  begin w = {m_ndy, m_eay, m_y}; m_ndy = 0; end
            5'd8:  w = m_cfga;
            5'd9:  w = m_cfgb;
            5'd30: begin w = {15'd0, m_fail}; m_fail = 0; end
            default: w = 16'h0000;
        endcase
    endtask

    // Driver: run one full frame, queue result and expectation, update model.
    task automatic frame(input logic [15:0] cmd, input string tag);
        logic [15:0] rx;
        spi_xfer(cmd, 16, rx);
        got_q.push_back(rx);
        exp_q.push_back('{exp_next, exp_tag});
        if (cmd[15]) begin
            if (cmd[13:9] == 5'd8) begin
                if (cmd[8]) m_cfga[15:8] = cmd[7:0]; else m_cfga[7:0] = cmd[7:0];
            end else if (cmd[13:9] == 5'd9) begin
                if (cmd[8]) m_cfgb[15:8] = cmd[7:0]; else m_cfgb[7:0] = cmd[7:0];
            end
            exp_next = 16'h0000;
            exp_tag  = "R5";
        end else begin
            model_read(cmd[13:8], exp_next);
            exp_tag = tag;
        end
    endtask

    task automatic abort_frame(input logic [15:0] cmd, input int nbits);
        logic [15:0] rx;
        spi_xfer(cmd, nbits, rx);
        m_fail   = 1;
        exp_next = 16'h0000;
        exp_tag  = "R8";
    endtask

    task automatic sample(input logic [13:0] x, input logic [13:0] y, input logic al);
        @(negedge clk);
        samp_x = x; samp_y = y; samp_alarm = al; samp_valid = 1'b1;
        @(negedge clk);
        samp_valid = 1'b0;
        m_x = x; m_y = y; m_eax = al; m_eay = al; m_ndx = 1; m_ndy = 1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1", {15'd0, spi_miso_oe}, 16'h0000);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1", {15'd0, spi_miso_oe}, 16'h0000);

        frame(16'h1300, "R3");          // read config B via odd address
        frame(16'h1200, "R3");          // same word via even address
        frame(16'h91A5, "R2");          // write A upper byte
        frame(16'h903C, "R2");          // write A lower byte
        frame(16'h10FF, "R2");          // read A, trailing junk (R4)
        frame(16'h1100, "R4");          // junk must not have written
        sample(14'h1234, 14'h2ABC, 1'b1);
        frame(16'h0200, "R6 R7");       // X: new data, alarm
        frame(16'h0300, "R6");          // X again: flag cleared
        frame(16'h0400, "R6 R7");       // Y word
        frame(16'h82FF, "R10");         // write to read-only data word
        frame(16'h0200, "R10");         // X unchanged
        frame(16'hA077, "R10");         // write unmapped
        frame(16'h2100, "R10");         // unmapped reads zero
        abort_frame(16'h9000, 7);       // R8: discarded write to A
        frame(16'h3C00, "R8");          // status shows abort
        frame(16'h1000, "R8");          // A untouched by aborted write
        frame(16'h3D00, "R8");          // status cleared by prior read

        // R9: clock and data activity with chip select high
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) spi_sclk = 1'b0; spi_mosi = 1'b1;
            repeat (HALF) @(posedge clk);
            @(negedge clk);
            check("R9", {15'd0, spi_miso_oe}, 16'h0000);
            spi_sclk = 1'b1;
            repeat (HALF) @(posedge clk);
        end
        frame(16'h1000, "R9");          // A still intact afterwards
        sample(14'h3FFF, 14'h0001, 1'b0);
        frame(16'h0300, "R7");          // alarm low captured
        frame(16'h0500, "R7");          // Y word, alarm low
        frame(16'h0000, "R10");         // drain last reply
        repeat (20) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule